// File: doc/BRIEF.md
# Four-beat burst address sequencer

This block produces the word address for a synchronous memory that runs bursts of up to four accesses from one start address. On a load edge the controller supplies a full external address. That address becomes the current address, and the burst starts at beat zero. On each later advance edge the beat count steps by one. The two lowest address bits are then re-derived from the start bits and the beat number. The bits above them keep the value that was loaded.

A static strap picks one of two beat orders. Interleaved order XORs the start bits with the beat number. Linear order adds the beat number to the start bits and wraps modulo four. An inactive clock enable freezes the whole block for that edge. A synchronous reset returns the address and the beat count to zero. The output address is combinational from the registered state and the strap, so it is valid in the cycle after the edge that updated the state.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge with `cen_n`=0 and `adv_ld`=0, `addr_in` is captured, and from the next cycle `addr_out` equals the captured value (beat 0).
- R2: On a rising edge with `cen_n`=0 and `adv_ld`=1, the beat number increments by one and `addr_in` has no effect on `addr_out`.
- R3: During advances, `addr_out[ADDR_W-1:2]` keeps the value loaded by the last load edge.
- R4: In interleaved order, beat n gives `addr_out[1:0]` = start XOR n (start 01 gives 01, 00, 11, 10).
- R5: In linear order, beat n gives `addr_out[1:0]` = (start + n) mod 4 (start 01 gives 01, 10, 11, 00).
- R6: `mode_il`=1 selects interleaved order and `mode_il`=0 selects linear order.
- R7: On a rising edge with `cen_n`=1, `addr_out` is unchanged whatever `adv_ld` and `addr_in` are.
- R8: Advancing past the fourth beat continues the same order within the same four-address group (beat n behaves as beat n mod 4).
- R9: A synchronous reset (`rst`=1 at a rising edge) gives `addr_out`=0 and beat 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high stalls the edge |
| adv_ld | input | 1 | 0 = load a start address, 1 = advance the burst |
| mode_il | input | 1 | Order strap: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |

## Verification
Each load, advance, stall or reset shows on `addr_out` one cycle after the rising edge that samples it. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs. The bench compares the full address on the next falling edge. Every comparison is tagged with the requirement that the previous edge's operation exercises, and long advance runs carry the beat number past four.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } bseq_op_e;
endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import bseq_pkg::*;
(
    input  logic     cen_n,
    input  logic     adv_ld,
    output bseq_op_e op
);
    always_comb begin
        if (cen_n)       op = OP_HOLD;
        else if (adv_ld) op = OP_STEP;
        else             op = OP_LOAD;
    end
endmodule

// File: rtl/bseq_core.sv
module bseq_core
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  bseq_op_e                 op,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-BEAT_W-1:0] hi_q_o,
    output logic [BEAT_W-1:0]        start_q_o,
    output logic [BEAT_W-1:0]        beat_q_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.hi    = addr_in[ADDR_W-1:BEAT_W];
                st_d.start = addr_in[BEAT_W-1:0];
                st_d.beat  = '0;
            end
            OP_STEP: st_d.beat = st_q.beat + 1'b1;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hi_q_o    = st_q.hi;
    assign start_q_o = st_q.start;
    assign beat_q_o  = st_q.beat;

    // R2 / R8: an advance steps the beat by one and wraps
    a_r2_beat_step: assert property (@(posedge clk) disable iff (rst)
        op == OP_STEP |=> beat_q_o == BEAT_W'($past(beat_q_o) + 1'b1));

    // R1: a load restarts the burst at beat zero
    a_r1_beat_zero: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> beat_q_o == '0);

    // R9: reset clears the state
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (beat_q_o == '0 && start_q_o == '0 && hi_q_o == '0));
endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              mode_il,
    output logic [BEAT_W-1:0] lo
);
    logic [BEAT_W-1:0] lo_xor;
    logic [BEAT_W-1:0] lo_add;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign lo_xor[i] = start[i] ^ beat[i];
    end

    assign lo_add = start + beat;

    always_comb begin
        lo = mode_il ? lo_xor : lo_add;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              adv_ld,
    input  logic              mode_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int BEAT_W = 2;
    localparam int HI_W   = ADDR_W - BEAT_W;

    bseq_op_e          op;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo;

    bseq_decode u_decode (
        .cen_n  (cen_n),
        .adv_ld (adv_ld),
        .op     (op)
    );

    bseq_core #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .addr_in   (addr_in),
        .hi_q_o    (hi_q),
        .start_q_o (start_q),
        .beat_q_o  (beat_q)
    );

    bseq_order #(.BEAT_W(BEAT_W)) u_order (
        .start   (start_q),
        .beat    (beat_q),
        .mode_il (mode_il),
        .lo      (lo)
    );

    assign addr_out = {hi_q, lo};

    // R1: a load shows the external address in the next cycle
    a_r1_load_visible: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld) |=> addr_out == $past(addr_in));

    // R3: an advance leaves the upper bits alone
    a_r3_upper_held: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld) |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    // R5: linear order counts up by one per advance
    a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld && !mode_il) |=>
            (!mode_il -> addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)));

    // R7: a stalled edge keeps the address
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(mode_il) -> $stable(addr_out)));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int ADDR_W = 18;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cen_n = 1'b1;
    logic              adv_ld = 1'b0;
    logic              mode_il = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    int m_hi = 0;
    int m_start = 0;
    int m_beat = 0;
    int m_kind = 0; // 0 reset, 1 load, 2 advance, 3 stall

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
        .clk(clk), .rst(rst), .cen_n(cen_n), .adv_ld(adv_ld),
        .mode_il(mode_il), .addr_in(addr_in), .addr_out(addr_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_hi = 0; m_start = 0; m_beat = 0; m_kind = 0;
        end else if (cen_n) begin
            m_kind = 3;
        end else if (!adv_ld) begin
            m_hi = int'(addr_in >> 2);
            m_start = int'(addr_in[1:0]);
            m_beat = 0;
            m_kind = 1;
        end else begin
            m_beat = m_beat + 1;
            m_kind = 2;
        end
    end

    function automatic logic [ADDR_W-1:0] model_addr();
        int n;
        int lo;
        n = m_beat % 4;
        lo = mode_il ? (m_start ^ n) : ((m_start + n) % 4);
        return {m_hi[ADDR_W-3:0], lo[1:0]};
    endfunction

    task automatic compare();
        logic [ADDR_W-1:0] exp;
        string tag;
        exp = model_addr();
        case (m_kind)
            0: tag = "R9";
            1: tag = "R1";
            2: tag = (m_beat >= 4) ? "R8" : (mode_il ? "R2 R4 R6" : "R2 R5 R6");
            default: tag = "R7";
        endcase
        total++;
        if (addr_out !== exp) begin
            bad++;
            $display("FAIL %s addr actual=%h expected=%h", tag, addr_out, exp);
        end
        if (m_kind == 2) begin
            total++;
            if (addr_out[ADDR_W-1:2] !== exp[ADDR_W-1:2]) begin
                bad++;
                $display("FAIL R3 upper actual=%h expected=%h",
                         addr_out[ADDR_W-1:2], exp[ADDR_W-1:2]);
            end
        end
    endtask

    task automatic step(input logic c, input logic a, input logic [ADDR_W-1:0] ad);
        cen_n = c; adv_ld = a; addr_in = ad;
        @(negedge clk);
        compare();
    endtask

    task automatic burst(input logic m, input logic [ADDR_W-1:0] start, input int beats);
        mode_il = m;
        step(1'b0, 1'b0, start);
        for (int i = 0; i < beats; i++)
            step(1'b0, 1'b1, ADDR_W'($urandom));
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        compare();                        // R9 reset value
        rst = 1'b0;
        mode_il = 1'b0;
        step(1'b0, 1'b1, '1);             // R9 advance from reset state
        burst(1'b0, 18'h2A5F5, 6);        // R5 linear from 01, wrap R8
        burst(1'b1, 18'h1B3C1, 6);        // R4 interleaved from 01, wrap R8
        burst(1'b1, 18'h3FFFE, 3);        // R4 start 10
        burst(1'b0, 18'h3FFFF, 5);        // R5 start 11, upper bits R3
        // R7 stall in mid-burst with noisy inputs
        burst(1'b0, 18'h00012, 1);
        step(1'b1, 1'b0, 18'h3ABCD);
        step(1'b1, 1'b1, 18'h15555);
        step(1'b0, 1'b1, 18'h00000);
        // R9 reset in mid-burst
        rst = 1'b1;
        step(1'b0, 1'b1, 18'h0);
        rst = 1'b0;
        // random mix
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 8) == 0) mode_il = ~mode_il;
            step(logic'(($urandom % 5) == 0), logic'(($urandom % 4) != 0),
                 ADDR_W'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule